// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Sequencer

This block runs single SPI flash transactions whose opcodes come from an eight-entry menu that software loads ahead of time. Each menu entry carries its own two-bit kind that says whether it reads or writes and whether it sends a 24-bit address. Software starts a transaction with one control write. That write names a menu entry, says whether a data phase follows and gives its length (1 to 64 bytes). It can also ask for an atomic sequence, in which a chosen prefix opcode (typically write-enable) goes out first in a frame of its own. The main command then follows, and after it a busy poll of the flash status register. Software sees the whole sequence as one job.

The block holds the 64-byte data buffer and the flash address register. Write-kind commands send bytes out of the buffer and read-kind commands fill it. An input pin freezes the menu and prefix registers. Registers sit on a simple word-addressed write port with a combinational read port.

Control flow is one state machine with the states ST_IDLE, ST_PFX_BYTE, ST_PFX_GAP, ST_CMD_BYTE, ST_ADDR_BYTE, ST_DATA_BYTE, ST_POLL_GAP, ST_POLL_CMD, ST_POLL_READ and ST_END. The transitions are:
- ST_IDLE moves to ST_PFX_BYTE (atomic) or ST_CMD_BYTE (plain) when a start is accepted.
- ST_PFX_BYTE moves to ST_PFX_GAP once the prefix byte is out.
- ST_PFX_GAP moves to ST_CMD_BYTE after the chip-select gap.
- ST_CMD_BYTE moves to ST_ADDR_BYTE, ST_DATA_BYTE, ST_POLL_GAP or ST_END, depending on the kind, the data flag and the atomic flag.
- ST_ADDR_BYTE moves on after its third byte, with the same choice of ST_DATA_BYTE, ST_POLL_GAP or ST_END.
- ST_DATA_BYTE moves to ST_POLL_GAP or ST_END after the last byte.
- ST_POLL_GAP moves to ST_POLL_CMD after the gap.
- ST_POLL_CMD moves to ST_POLL_READ.
- ST_POLL_READ stays while the status byte has bit 0 set and then moves to ST_END.
- ST_END returns to ST_IDLE.

Top module: `opm_spi_seq`

## Requirements
- R1: Menu entry i (0..3) is byte i (bits 8i+7:8i) of the menu-low register (word 2), and entry i+4 is byte i of the menu-high register (word 3). A started cycle sends the selected entry's opcode as the first byte of its frame. The SPI is mode 0, MSB first: MOSI changes while SCK is low, and MISO is sampled on the rising edge.
- R2: The prefix/kind register (word 1) holds prefix 0 in bits 7:0, prefix 1 in bits 15:8, and the kind of entry k in bits 17+2k:16+2k. The kinds are 0 read without address, 1 write without address, 2 read with address and 3 write with address. Kinds 2 and 3 send bits 23:16, 15:8 and 7:0 of the address register (word 4) in that order, right after the opcode.
- R3: In the control register (word 0), bits 14:12 are the menu index, bits 21:16 are the byte count minus one and bit 22 is the data flag. With the flag set, count+1 data bytes follow. Write kinds send buffer byte k, which is word 16+k/4, bits 8(k%4)+7:8(k%4). Read kinds send 0x00 and store the received byte k into that buffer byte. With the flag clear, no data byte is sent.
- R4: Bit 9 starts a cycle. With bit 10 set, the cycle sends three frames, each ended by chip select rising: (a) the prefix opcode alone, bits 15:8 of word 1 when bit 11 is set and bits 7:0 when it is clear; (b) the main command; (c) a poll frame of opcode 0x05 followed by 0x00 bytes, read until a returned status byte has bit 0 clear. Without bit 10, only the main frame is sent.
- R5: A start that has bit 10 set and selects a read kind (0 or 2) causes no SPI activity and sets the cycle-error bit 3.
- R6: A start written while in-progress (bit 0) is set sets the access-error bit 4 and does not change the running cycle.
- R7: Done (bit 2), cycle error (bit 3) and access error (bit 4) clear only when 1 is written to them. Writing 0 leaves them.
- R8: While lock_i is high, writes to words 1, 2 and 3 are ignored.
- R9: In-progress is set from the accepted start until the cycle ends, including the whole poll frame. Done sets in the same cycle that in-progress clears. Chip select stays high whenever no cycle is in progress.
- R10: After reset, every register and status bit reads 0, chip select is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Freezes the menu and prefix/kind registers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: 0..4 registers, 16..31 data buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_addr |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A flash model in the bench records every byte of every chip-select frame. It answers with a position-dependent pattern, and with a programmable number of busy status bytes on a poll. All four kinds are run with and without data and at byte counts 1 and 64, so an address phase sent for the wrong kind, or a data length that is one off, shows up as a wrong frame length. Atomic cycles are run with both prefix selections and with zero to three busy status bytes. This separates a wrong prefix slot, a missing chip-select rise between frames and a poll that stops early. Random menus, kinds, addresses and buffer contents catch a wrong byte lane in the menu or buffer mapping. Directed cases cover a rejected atomic read, a start during a running cycle and writes under lock.

// File: rtl/opm_spi_pkg.sv
package opm_spi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PFX_BYTE,
        ST_PFX_GAP,
        ST_CMD_BYTE,
        ST_ADDR_BYTE,
        ST_DATA_BYTE,
        ST_POLL_GAP,
        ST_POLL_CMD,
        ST_POLL_READ,
        ST_END
    } seq_state_e;

    // word addresses of the control registers
    localparam int REG_CTRL = 0;
    localparam int REG_PFX  = 1;
    localparam int REG_MLO  = 2;
    localparam int REG_MHI  = 3;
    localparam int REG_FADR = 4;

    // control/status bit positions
    localparam int B_BUSY   = 0;
    localparam int B_DONE   = 2;
    localparam int B_CERR   = 3;
    localparam int B_AERR   = 4;
    localparam int B_GO     = 9;
    localparam int B_ATOM   = 10;
    localparam int B_PSEL   = 11;
    localparam int B_IDX_LO = 12;
    localparam int B_CNT_LO = 16;
    localparam int B_DS     = 22;

    // kind field: bit 0 = write direction, bit 1 = address phase
    function automatic logic kind_is_write(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_has_addr(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/opm_data_buf.sv
module opm_data_buf #(
    parameter int BYTES = 64,
    localparam int WORDS = BYTES / 4,
    localparam int WI_W  = $clog2(WORDS),
    localparam int BI_W  = $clog2(BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [WI_W-1:0] bus_widx,
    input  logic [31:0]     bus_wdata,
    input  logic [WI_W-1:0] bus_ridx,
    output logic [31:0]     bus_rdata,
    input  logic            eng_we,
    input  logic [BI_W-1:0] eng_idx,
    input  logic [7:0]      eng_wbyte,
    output logic [7:0]      eng_rbyte
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'h00;
        end else begin
            if (bus_we) begin
                for (int l = 0; l < 4; l++)
                    mem[{bus_widx, 2'(l)}] <= bus_wdata[8*l +: 8];
            end
            // engine write wins over a bus write to the same byte
            if (eng_we) mem[eng_idx] <= eng_wbyte;
        end
    end

    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign bus_rdata[8*l +: 8] = mem[{bus_ridx, 2'(l)}];
    end

    assign eng_rbyte = mem[eng_idx];

endmodule

// File: rtl/opm_menu_bank.sv
module opm_menu_bank #(
    parameter int ENTRIES = 8,
    localparam int PER_REG = ENTRIES / 2,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             we_pfx,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             pfx_sel,
    output logic [7:0]       sel_op,
    output logic [1:0]       sel_kind,
    output logic [7:0]       pfx_op,
    output logic [31:0]      pfx_word,
    output logic [31:0]      lo_word,
    output logic [31:0]      hi_word
);

    logic [31:0] pfx_q, lo_q, hi_q;
    logic [7:0]  ent_op   [ENTRIES];
    logic [1:0]  ent_kind [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (!lock_i) begin
            if (we_pfx) pfx_q <= wdata;
            if (we_lo)  lo_q  <= wdata;
            if (we_hi)  hi_q  <= wdata;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        if (e < PER_REG) begin : g_low
            assign ent_op[e] = lo_q[8*e +: 8];
        end else begin : g_high
            assign ent_op[e] = hi_q[8*(e-PER_REG) +: 8];
        end
        assign ent_kind[e] = pfx_q[16 + 2*e +: 2];
    end

    assign sel_op   = ent_op[sel_idx];
    assign sel_kind = ent_kind[sel_idx];
    assign pfx_op   = pfx_sel ? pfx_q[15:8] : pfx_q[7:0];
    assign pfx_word = pfx_q;
    assign lo_word  = lo_q;
    assign hi_word  = hi_q;

endmodule

// File: rtl/opm_spi_shifter.sv
module opm_spi_shifter #(
    parameter int HALF_DIV = 2,
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       spi_miso,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       spi_sck,
    output logic       spi_mosi
);

    logic          active;
    logic [2:0]    bit_cnt;
    logic [HW-1:0] half_cnt;
    logic          sck_q;
    logic [7:0]    tx_q, rx_q;
    logic          half_tick;

    assign half_tick = (half_cnt == HW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            half_cnt <= '0;
            sck_q    <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else if (!active) begin
            if (go) begin
                active   <= 1'b1;
                tx_q     <= tx_byte;
                bit_cnt  <= 3'd7;
                half_cnt <= '0;
                sck_q    <= 1'b0;
            end
        end else if (half_tick) begin
            half_cnt <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_q  <= {rx_q[6:0], spi_miso};
            end else begin
                sck_q <= 1'b0;
                if (bit_cnt == 3'd0) begin
                    active <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt - 3'd1;
                    tx_q    <= {tx_q[6:0], 1'b0};
                end
            end
        end else begin
            half_cnt <= half_cnt + HW'(1);
        end
    end

    assign byte_done = active && sck_q && half_tick && (bit_cnt == 3'd0);
    assign rx_byte   = rx_q;
    assign spi_sck   = sck_q;
    assign spi_mosi  = tx_q[7];

endmodule

// File: rtl/opm_spi_seq.sv
module opm_spi_seq
    import opm_spi_pkg::*;
#(
    parameter int         HALF_DIV  = 2,
    parameter int         CS_GAP    = 3,
    parameter int         BUF_BYTES = 64,
    parameter logic [7:0] POLL_OP   = 8'h05,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int WI_W      = $clog2(BUF_WORDS),
    localparam int CNT_W     = $clog2(BUF_BYTES),
    localparam int RA_W      = WI_W + 1,
    localparam int GAP_W     = (CS_GAP > 1) ? $clog2(CS_GAP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_i,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);

    seq_state_e state_q, state_d;

    // status and latched command
    logic             busy_q, done_q, cerr_q, aerr_q;
    logic [2:0]       l_idx;
    logic [CNT_W-1:0] l_cnt;
    logic             l_ds, l_atom, l_psel;
    logic [7:0]       l_op, l_pfx;
    logic [1:0]       l_kind;
    logic [23:0]      fadr_q;

    logic [CNT_W-1:0] byte_i;
    logic [GAP_W-1:0] gap_cnt;

    // bus decode
    logic is_buf, ctrl_wr, go_req, reject, launch, collide;
    logic [WI_W-1:0] reg_word;

    assign is_buf   = reg_addr[RA_W-1];
    assign reg_word = reg_addr[WI_W-1:0];
    assign ctrl_wr  = reg_we && (reg_addr == RA_W'(REG_CTRL));
    assign go_req   = ctrl_wr && reg_wdata[B_GO];

    // menu bank
    logic [7:0]  m_op, m_pfx;
    logic [1:0]  m_kind;
    logic [31:0] pfx_word, lo_word, hi_word;

    opm_menu_bank #(.ENTRIES(8)) u_menu (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (lock_i),
        .we_pfx   (reg_we && (reg_addr == RA_W'(REG_PFX))),
        .we_lo    (reg_we && (reg_addr == RA_W'(REG_MLO))),
        .we_hi    (reg_we && (reg_addr == RA_W'(REG_MHI))),
        .wdata    (reg_wdata),
        .sel_idx  (reg_wdata[B_IDX_LO +: 3]),
        .pfx_sel  (reg_wdata[B_PSEL]),
        .sel_op   (m_op),
        .sel_kind (m_kind),
        .pfx_op   (m_pfx),
        .pfx_word (pfx_word),
        .lo_word  (lo_word),
        .hi_word  (hi_word)
    );

    assign reject  = go_req && !busy_q && reg_wdata[B_ATOM] && !kind_is_write(m_kind);
    assign launch  = go_req && !busy_q && !reject;
    assign collide = go_req && busy_q;

    // byte shifter
    logic       sh_go, sh_done;
    logic [7:0] sh_tx, sh_rx;

    opm_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (sh_go),
        .tx_byte   (sh_tx),
        .spi_miso  (spi_miso),
        .rx_byte   (sh_rx),
        .byte_done (sh_done),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi)
    );

    // data buffer
    logic        eng_we;
    logic [7:0]  eng_rbyte;
    logic [31:0] buf_rdata;

    opm_data_buf #(.BYTES(BUF_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (reg_we && is_buf),
        .bus_widx  (reg_word),
        .bus_wdata (reg_wdata),
        .bus_ridx  (reg_word),
        .bus_rdata (buf_rdata),
        .eng_we    (eng_we),
        .eng_idx   (byte_i),
        .eng_wbyte (sh_rx),
        .eng_rbyte (eng_rbyte)
    );

    // status, command latch and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cerr_q <= 1'b0;
            aerr_q <= 1'b0;
            l_idx  <= '0;
            l_cnt  <= '0;
            l_ds   <= 1'b0;
            l_atom <= 1'b0;
            l_psel <= 1'b0;
            l_op   <= '0;
            l_pfx  <= '0;
            l_kind <= '0;
            fadr_q <= '0;
        end else begin
            if (reg_we && (reg_addr == RA_W'(REG_FADR)))
                fadr_q <= reg_wdata[23:0];
            if (ctrl_wr) begin
                if (reg_wdata[B_DONE]) done_q <= 1'b0;
                if (reg_wdata[B_CERR]) cerr_q <= 1'b0;
                if (reg_wdata[B_AERR]) aerr_q <= 1'b0;
            end
            if (reject)  cerr_q <= 1'b1;
            if (collide) aerr_q <= 1'b1;
            if (launch) begin
                busy_q <= 1'b1;
                l_idx  <= reg_wdata[B_IDX_LO +: 3];
                l_cnt  <= reg_wdata[B_CNT_LO +: CNT_W];
                l_ds   <= reg_wdata[B_DS];
                l_atom <= reg_wdata[B_ATOM];
                l_psel <= reg_wdata[B_PSEL];
                l_op   <= m_op;
                l_pfx  <= m_pfx;
                l_kind <= m_kind;
            end
            if (state_q == ST_END) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte and gap counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_i  <= '0;
            gap_cnt <= '0;
        end else begin
            if (state_q != state_d) byte_i <= '0;
            else if (sh_done)       byte_i <= byte_i + CNT_W'(1);
            if (state_q == ST_PFX_GAP || state_q == ST_POLL_GAP)
                gap_cnt <= gap_cnt + GAP_W'(1);
            else
                gap_cnt <= '0;
        end
    end

    logic       gap_last;
    seq_state_e after_main;

    assign gap_last   = (gap_cnt == GAP_W'(CS_GAP - 1));
    assign after_main = l_atom ? ST_POLL_GAP : ST_END;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (launch) state_d = reg_wdata[B_ATOM] ? ST_PFX_BYTE : ST_CMD_BYTE;
            ST_PFX_BYTE:
                if (sh_done) state_d = ST_PFX_GAP;
            ST_PFX_GAP:
                if (gap_last) state_d = ST_CMD_BYTE;
            ST_CMD_BYTE:
                if (sh_done) begin
                    if (kind_has_addr(l_kind)) state_d = ST_ADDR_BYTE;
                    else if (l_ds)             state_d = ST_DATA_BYTE;
                    else                       state_d = after_main;
                end
            ST_ADDR_BYTE:
                if (sh_done && byte_i == CNT_W'(2))
                    state_d = l_ds ? ST_DATA_BYTE : after_main;
            ST_DATA_BYTE:
                if (sh_done && byte_i == l_cnt) state_d = after_main;
            ST_POLL_GAP:
                if (gap_last) state_d = ST_POLL_CMD;
            ST_POLL_CMD:
                if (sh_done) state_d = ST_POLL_READ;
            ST_POLL_READ:
                if (sh_done && !sh_rx[0]) state_d = ST_END;
            ST_END:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        sh_go  = 1'b0;
        sh_tx  = 8'h00;
        eng_we = 1'b0;
        unique case (state_q)
            ST_PFX_BYTE: begin
                sh_go = 1'b1;
                sh_tx = l_pfx;
            end
            ST_CMD_BYTE: begin
                sh_go = 1'b1;
                sh_tx = l_op;
            end
            ST_ADDR_BYTE: begin
                sh_go = 1'b1;
                unique case (byte_i)
                    CNT_W'(0): sh_tx = fadr_q[23:16];
                    CNT_W'(1): sh_tx = fadr_q[15:8];
                    default:   sh_tx = fadr_q[7:0];
                endcase
            end
            ST_DATA_BYTE: begin
                sh_go  = 1'b1;
                sh_tx  = kind_is_write(l_kind) ? eng_rbyte : 8'h00;
                eng_we = sh_done && !kind_is_write(l_kind);
            end
            ST_POLL_CMD: begin
                sh_go = 1'b1;
                sh_tx = POLL_OP;
            end
            ST_POLL_READ: begin
                sh_go = 1'b1;
            end
            default: ;
        endcase
    end

    assign spi_cs_n = !(state_q == ST_PFX_BYTE  || state_q == ST_CMD_BYTE  ||
                        state_q == ST_ADDR_BYTE || state_q == ST_DATA_BYTE ||
                        state_q == ST_POLL_CMD  || state_q == ST_POLL_READ);

    // register read port
    logic [31:0] ctrl_word;
    always_comb begin
        ctrl_word = '0;
        ctrl_word[B_BUSY]             = busy_q;
        ctrl_word[B_DONE]             = done_q;
        ctrl_word[B_CERR]             = cerr_q;
        ctrl_word[B_AERR]             = aerr_q;
        ctrl_word[B_ATOM]             = l_atom;
        ctrl_word[B_PSEL]             = l_psel;
        ctrl_word[B_IDX_LO +: 3]      = l_idx;
        ctrl_word[B_CNT_LO +: CNT_W]  = l_cnt;
        ctrl_word[B_DS]               = l_ds;
    end

    always_comb begin
        if (is_buf) begin
            reg_rdata = buf_rdata;
        end else begin
            case (reg_addr)
                RA_W'(REG_CTRL): reg_rdata = ctrl_word;
                RA_W'(REG_PFX):  reg_rdata = pfx_word;
                RA_W'(REG_MLO):  reg_rdata = lo_word;
                RA_W'(REG_MHI):  reg_rdata = hi_word;
                RA_W'(REG_FADR): reg_rdata = {8'h00, fadr_q};
                default:         reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/opm_spi_seq_chk.sv
module opm_spi_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic busy,
    input logic done,
    input logic cerr,
    input logic aerr
);

    AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R9

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R1

    AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy)); // R9

    AST_REJECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cerr) |-> !busy); // R5

    AST_AERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aerr) |-> $past(busy)); // R6

    AST_SELECT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> busy); // R4

endmodule

bind opm_spi_seq opm_spi_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .busy     (busy_q),
    .done     (done_q),
    .cerr     (cerr_q),
    .aerr     (aerr_q)
);

// File: tb/opm_spi_seq_bench.sv
module opm_spi_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b1;

    always #5 clk = ~clk;

    opm_spi_seq u_opm_spi_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (lock_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] logb [512];
    int         fstart [8];
    int         flen [8];
    int         nfr = 0, nlog = 0;
    int         busy_left = 0;
    int         m_bit = 0, m_byte = 0;
    bit         m_open = 0;
    logic [7:0] m_sh = 0, m_out = 8'hFF, m_first = 0;

    function automatic logic [7:0] pat(input int p);
        return 8'(p * 29 + 51);
    endfunction

    always @(negedge spi_cs_n) begin
        m_open = 1; m_bit = 0; m_byte = 0; m_out = 8'hFF;
        spi_miso = m_out[7];
        if (nfr < 8) fstart[nfr] = nlog;
    end

    always @(posedge spi_cs_n) begin
        if (m_open) begin
            if (nfr < 8) flen[nfr] = m_byte;
            nfr++;
            m_open = 0;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            logic [7:0] nb;
            nb = {m_sh[6:0], spi_mosi};
            m_sh = nb;
            m_bit++;
            if (m_bit == 8) begin
                if (nlog < 512) logb[nlog] = nb;
                nlog++;
                if (m_byte == 0) m_first = nb;
                else if (m_first == 8'h05 && busy_left > 0) busy_left--;
                m_byte++;
                m_bit = 0;
                m_out = (m_first == 8'h05) ? ((busy_left > 0) ? 8'h01 : 8'h00) : pat(m_byte);
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) spi_miso = m_out[7 - m_bit];
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    // ---------------- shadow state ----------------
    logic [31:0] sh_lo, sh_hi, sh_pfx;
    logic [23:0] sh_adr;
    logic [7:0]  sh_buf [64];

    function automatic logic [7:0] op_of(input int idx);
        return (idx < 4) ? sh_lo[8*idx +: 8] : sh_hi[8*(idx-4) +: 8];
    endfunction

    function automatic logic [1:0] kind_of(input int idx);
        return sh_pfx[16 + 2*idx +: 2];
    endfunction

    function automatic logic [31:0] ctrl_go(input int idx, input bit ds, input int cnt,
                                            input bit atom, input bit psel);
        return (32'(ds) << 22) | (32'(cnt) << 16) | (32'(idx) << 12) |
               (32'(psel) << 11) | (32'(atom) << 10) | 32'h200;
    endfunction

    task automatic load_buf();
        for (int w = 0; w < 16; w++) begin
            logic [31:0] v;
            v = $urandom;
            for (int l = 0; l < 4; l++) sh_buf[4*w + l] = v[8*l +: 8];
            wr(16 + w, v);
        end
    endtask

    task automatic run_cycle(input string req, input int idx, input bit ds, input int cnt,
                             input bit atom, input bit psel, input int nbusy, input bit collide);
        logic [7:0]  e [512];
        int          ef [4];
        int          ne, nf, p0;
        logic [31:0] s;
        logic [1:0]  k;
        bit          ok;
        k = kind_of(idx);
        nfr = 0; nlog = 0; busy_left = nbusy;
        wr(0, ctrl_go(idx, ds, cnt, atom, psel));
        if (atom && !k[0]) begin
            repeat (60) @(negedge clk);
            rd(0, s);
            check(s[3] == 1'b1 && s[0] == 1'b0, req, "reject sets error, no busy", s, 32'h8);
            check(nfr == 0, req, "reject sends no frame", 32'(nfr), 0);
            wr(0, 32'h1C);
            return;
        end
        if (collide) begin
            repeat (40) @(negedge clk);
            wr(0, ctrl_go((idx + 1) % 8, 1'b0, 0, 1'b0, 1'b0));
        end
        do rd(0, s); while (s[0]);
        // expected frames
        ne = 0; nf = 0;
        if (atom) begin
            e[ne++] = psel ? sh_pfx[15:8] : sh_pfx[7:0];
            ef[nf++] = 1;
        end
        p0 = ne;
        e[ne++] = op_of(idx);
        if (k[1]) begin
            e[ne++] = sh_adr[23:16]; e[ne++] = sh_adr[15:8]; e[ne++] = sh_adr[7:0];
        end
        if (ds) begin
            for (int b = 0; b <= cnt; b++) e[ne++] = k[0] ? sh_buf[b] : 8'h00;
        end
        ef[nf++] = ne - p0;
        if (atom) begin
            e[ne++] = 8'h05;
            for (int b = 0; b <= nbusy; b++) e[ne++] = 8'h00;
            ef[nf++] = nbusy + 2;
        end
        check(nfr == nf, req, "frame count", 32'(nfr), 32'(nf));
        ok = (nlog == ne);
        for (int f = 0; f < nf && f < nfr; f++) if (flen[f] != ef[f]) ok = 0;
        for (int b = 0; b < ne && b < nlog; b++) if (logb[b] != e[b]) begin
            if (ok) $display("  byte %0d: got %h want %h", b, logb[b], e[b]);
            ok = 0;
        end
        check(ok, req, "frame bytes", 32'(nlog), 32'(ne));
        check(s[2] == 1'b1 && s[3] == 1'b0 && s[4] == collide, "R9",
              "status after cycle", s & 32'h1F, {27'd0, collide, 3'b010, 1'b0});
        if (ds && !k[0]) begin
            ok = 1;
            for (int b = 0; b <= cnt; b++) sh_buf[b] = pat(1 + (k[1] ? 3 : 0) + b);
            for (int w = 0; w <= cnt / 4; w++) begin
                rd(16 + w, s);
                for (int l = 0; l < 4; l++)
                    if (4*w + l <= cnt && s[8*l +: 8] != sh_buf[4*w + l]) ok = 0;
            end
            check(ok, "R3", "read data stored in buffer", s, 0);
        end
        wr(0, 32'h1C);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R10", "pins in reset",
              {30'd0, spi_cs_n, spi_sck}, 32'h2);
        rst_n = 1'b1;
        rd(0, s); check(s == 0, "R10", "control after reset", s, 0);
        rd(2, s); check(s == 0, "R10", "menu low after reset", s, 0);
        rd(1, s); check(s == 0, "R10", "prefix after reset", s, 0);

        // directed menu: e0 read+addr, e1 write+addr, e2 write, e3 read
        sh_lo  = 32'h9F_02_D8_03;
        sh_hi  = 32'h01_35_0B_C7;
        sh_pfx = 32'hD1E4_5006 & 32'hFFFF_FFFF;
        sh_pfx[23:16] = {2'd0, 2'd1, 2'd3, 2'd2};
        sh_adr = 24'h12_34_56;
        wr(2, sh_lo); wr(3, sh_hi); wr(1, sh_pfx); wr(4, {8'h00, sh_adr});
        load_buf();

        run_cycle("R1", 3, 1, 2, 0, 0, 0, 0);      // read no addr, 3 bytes
        run_cycle("R2", 0, 1, 63, 0, 0, 0, 0);     // read with addr, 64 bytes
        run_cycle("R3", 1, 1, 0, 0, 0, 0, 0);      // write with addr, 1 byte
        run_cycle("R3", 2, 0, 9, 0, 0, 0, 0);      // no data phase
        run_cycle("R4", 1, 1, 5, 1, 0, 2, 0);      // atomic, prefix 0, busy twice
        run_cycle("R4", 2, 0, 0, 1, 1, 0, 0);      // atomic, prefix 1, ready at once
        run_cycle("R5", 0, 1, 3, 1, 0, 0, 0);      // atomic on read kind
        run_cycle("R5", 3, 0, 0, 1, 1, 0, 0);
        run_cycle("R6", 1, 1, 20, 0, 0, 0, 1);     // start during running cycle

        // R7: write-1-to-clear
        run_cycle("R2", 5, 1, 7, 0, 0, 0, 0);
        wr(0, ctrl_go(2, 0, 0, 0, 0));
        do rd(0, s); while (s[0]);
        wr(0, 32'h0);
        rd(0, s); check(s[2] == 1'b1, "R7", "done kept after write of 0", s[2], 1);
        wr(0, 32'h4);
        rd(0, s); check(s[2] == 1'b0, "R7", "done cleared by write of 1", s[2], 0);

        // R8: lock
        lock_i = 1'b1;
        wr(2, 32'hDEAD_BEEF); wr(3, 32'h0BAD_F00D); wr(1, 32'h5555_AAAA);
        rd(2, s); check(s == sh_lo, "R8", "menu low held", s, sh_lo);
        rd(3, s); check(s == sh_hi, "R8", "menu high held", s, sh_hi);
        rd(1, s); check(s == sh_pfx, "R8", "prefix held", s, sh_pfx);
        run_cycle("R8", 2, 0, 0, 0, 0, 0, 0);
        lock_i = 1'b0;

        // constrained random cycles
        for (int it = 0; it < 12; it++) begin
            int idx, cnt;
            bit ds, atom, psel;
            sh_lo = $urandom; sh_hi = $urandom; sh_pfx = $urandom;
            sh_adr = 24'($urandom);
            wr(2, sh_lo); wr(3, sh_hi); wr(1, sh_pfx); wr(4, {8'h00, sh_adr});
            load_buf();
            idx  = int'($urandom % 8);
            cnt  = int'($urandom % 64);
            ds   = 1'($urandom);
            atom = 1'($urandom);
            psel = 1'($urandom);
            run_cycle("R1", idx, ds, cnt, atom, psel, int'($urandom % 4), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule